// File: doc/BRIEF.md
# Two-Operand ALU with Condition Flags

This block is the arithmetic and logic stage of a small processor datapath that executes two-operand instructions. It takes a 4-bit operation code, a source operand and a destination operand, a byte/word select and the incoming carry. In the same cycle it returns the result, a write-back strobe and the four condition flags. Each flag has its own update enable, so the register that holds the status word keeps any flag the operation does not touch.

The block is purely combinational and has no clock. Operand fetch, address generation and the register file sit upstream. The status register and the write-back path sit downstream. No data stream crosses its edge, so there is no valid/ready handshake and no back-pressure. All pins are plain control and data levels, valid whenever the inputs are stable.

Subtraction is formed as the destination plus the inverted source plus one or plus the carry. Compare and bit test run the subtract and AND paths but suppress write-back. A packed-BCD add with carry is included.

Top module: `dual_op_alu`

## Requirements
- R1: Operation codes are: 4 move, 5 add, 6 add-with-carry, 7 subtract-with-carry, 8 subtract, 9 compare, A decimal add, B bit test, C bit clear, D bit set, E exclusive-or, F and. Codes 0 to 3 give result 0, no write-back and no flag update.
- R2: Add gives src + dst, and add-with-carry gives src + dst + carry_i. C is the carry out of the active most significant bit. V is set when the signed sum leaves the signed range.
- R3: Subtract gives dst + NOT(src) + 1, and subtract-with-carry gives dst + NOT(src) + carry_i. C is the carry out of that sum, so it is 1 when no borrow occurs. V is set when the signed result of that sum leaves the signed range.
- R4: Compare produces the subtract result and flags, and bit test produces the AND result and flags. Both hold wr_en_o low. Every other valid code drives wr_en_o high.
- R5: Decimal add treats each 4-bit nibble as one decimal digit and adds src, dst and carry_i digit by digit, starting at the lowest nibble. A digit sum above 9 is reduced by ten modulo 16 and passes a carry to the next digit. C is the carry out of the top active digit, and V is cleared.
- R6: AND and bit test give src AND dst, clear V and set C to the inverse of Z.
- R7: Exclusive-or gives src XOR dst. V is set when both operands have the active sign bit set, and C is the inverse of Z.
- R8: Move passes src, bit clear gives NOT(src) AND dst, and bit set gives src OR dst. All three leave flag_upd_o at 0000.
- R9: With byte_i high, only bits 7:0 of the operands are used. Result bits 15:8 are zero, N comes from bit 7 and C is the carry out of bit 7 (decimal add: out of the second digit).
- R10: flags_o and flag_upd_o share the bit order [3]=V, [2]=N, [1]=Z, [0]=C. For codes 5 to B, E and F all four enables are set, N equals the active sign bit of the result and Z is 1 exactly when the active result bits are zero. A flag value is meaningful only where its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| byte_i | input | 1 | 1 selects byte width, 0 selects word width |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 16 | Operation result |
| wr_en_o | output | 1 | Result is to be written to the destination |
| flags_o | output | 4 | New flag values {V,N,Z,C} |
| flag_upd_o | output | 4 | Per-flag update enables {V,N,Z,C} |

## Verification
The assertions assume that the operation code and byte select carry no unknown bits while they evaluate. The digit-range check on the decimal adder applies only when both operand nibbles are valid decimal digits. The bench drives every input from fixed values at a known time, so no unknown value ever reaches the block. It mixes random operands, including invalid BCD nibbles, with hand-picked boundary vectors. The digit-range assertion guards its own premise and stays silent for invalid digits.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [3:0] OP_MOV  = 4'h4;
  localparam logic [3:0] OP_ADD  = 4'h5;
  localparam logic [3:0] OP_ADDC = 4'h6;
  localparam logic [3:0] OP_SUBC = 4'h7;
  localparam logic [3:0] OP_SUB  = 4'h8;
  localparam logic [3:0] OP_CMP  = 4'h9;
  localparam logic [3:0] OP_DADD = 4'hA;
  localparam logic [3:0] OP_BIT  = 4'hB;
  localparam logic [3:0] OP_BIC  = 4'hC;
  localparam logic [3:0] OP_BIS  = 4'hD;
  localparam logic [3:0] OP_XOR  = 4'hE;
  localparam logic [3:0] OP_AND  = 4'hF;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_COUNT = 4;

  typedef logic [FLG_COUNT-1:0] flag_vec_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         byte_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  localparam int H = W / 2;

  logic [W:0] full;
  logic       sa, sb, sr;

  always_comb begin
    full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o = full[W-1:0];
    c_o   = byte_i ? full[H] : full[W];
    sa    = byte_i ? a_i[H-1] : a_i[W-1];
    sb    = byte_i ? b_i[H-1] : b_i[W-1];
    sr    = byte_i ? full[H-1] : full[W-1];
    v_o   = (sa == sb) && (sr != sa);
  end

  // Byte operands arrive with upper halves zero: only bit H may carry in.
  always_comb begin
    if (!$isunknown(byte_i) && byte_i && a_i[W-1:H] == '0 && b_i[W-1:H] == '0)
      assert_byte_upper_R9: assert (full[W:H+1] == '0)
        else $error("adder byte sum spilled above bit %0d", H);
  end
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         byte_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  localparam int DIGITS = W / 4;
  localparam int HALF_D = DIGITS / 2;

  logic [DIGITS:0] cy;
  assign cy[0] = cin_i;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [4:0] raw;
    logic       over;
    always_comb begin
      raw  = {1'b0, a_i[4*d +: 4]} + {1'b0, b_i[4*d +: 4]} + {4'd0, cy[d]};
      over = raw > 5'd9;
      sum_o[4*d +: 4] = over ? 4'(raw - 5'd10) : raw[3:0];
      cy[d+1] = over;
    end

    // Valid decimal digits in must give a valid decimal digit out.
    always_comb begin
      if (!$isunknown({a_i[4*d +: 4], b_i[4*d +: 4], cy[d]}) &&
          a_i[4*d +: 4] <= 4'd9 && b_i[4*d +: 4] <= 4'd9)
        assert_digit_range_R5: assert (sum_o[4*d +: 4] <= 4'd9)
          else $error("decimal digit %0d out of range", d);
    end
  end

  assign c_o = byte_i ? cy[HALF_D] : cy[DIGITS];
endmodule

// File: rtl/dual_op_alu.sv
module dual_op_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              byte_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o,
  output logic [3:0]        flag_upd_o
);
  localparam int H = DATA_W / 2;

  logic [DATA_W-1:0] mask, s_m, d_m, add_a, add_sum, bcd_sum, raw, res;
  logic              is_sub, add_cin, add_c, add_v, bcd_c;
  logic              n_f, z_f;

  assign mask  = byte_i ? {{(DATA_W-H){1'b0}}, {H{1'b1}}} : {DATA_W{1'b1}};
  assign s_m   = src_i & mask;
  assign d_m   = dst_i & mask;
  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
  assign add_a  = is_sub ? (~src_i & mask) : s_m;

  always_comb begin
    unique case (op_i)
      OP_ADDC, OP_SUBC: add_cin = carry_i;
      OP_SUB, OP_CMP:   add_cin = 1'b1;
      default:          add_cin = 1'b0;
    endcase
  end

  alu_adder #(.W(DATA_W)) u_adder (
    .a_i(add_a), .b_i(d_m), .cin_i(add_cin), .byte_i(byte_i),
    .sum_o(add_sum), .c_o(add_c), .v_o(add_v)
  );

  alu_bcd #(.W(DATA_W)) u_bcd (
    .a_i(s_m), .b_i(d_m), .cin_i(carry_i), .byte_i(byte_i),
    .sum_o(bcd_sum), .c_o(bcd_c)
  );

  assign res = raw & mask;
  assign n_f = byte_i ? res[H-1] : res[DATA_W-1];
  assign z_f = (res == '0);
  assign result_o = res;

  always_comb begin
    raw        = '0;
    wr_en_o    = 1'b1;
    flag_upd_o = 4'b1111;
    flags_o    = '0;
    flags_o[FLG_N] = n_f;
    flags_o[FLG_Z] = z_f;
    case (op_i)
      OP_MOV: begin raw = s_m; flag_upd_o = '0; end
      OP_BIC: begin raw = ~s_m & d_m; flag_upd_o = '0; end
      OP_BIS: begin raw = s_m | d_m; flag_upd_o = '0; end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        raw = add_sum;
        flags_o[FLG_C] = add_c;
        flags_o[FLG_V] = add_v;
        wr_en_o = (op_i != OP_CMP);
      end
      OP_DADD: begin
        raw = bcd_sum;
        flags_o[FLG_C] = bcd_c;
      end
      OP_AND, OP_BIT: begin
        raw = s_m & d_m;
        flags_o[FLG_C] = ~z_f;
        wr_en_o = (op_i != OP_BIT);
      end
      OP_XOR: begin
        raw = s_m ^ d_m;
        flags_o[FLG_C] = ~z_f;
        flags_o[FLG_V] = byte_i ? (src_i[H-1] & dst_i[H-1])
                                : (src_i[DATA_W-1] & dst_i[DATA_W-1]);
      end
      default: begin
        wr_en_o    = 1'b0;
        flag_upd_o = '0;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, byte_i})) begin
      if (byte_i)
        assert_byte_clean_R9: assert (result_o[DATA_W-1:H] == '0)
          else $error("byte result has upper bits set");
      if (op_i == OP_CMP || op_i == OP_BIT || op_i < OP_MOV)
        assert_no_writeback_R4: assert (!wr_en_o)
          else $error("write-back asserted for non-storing code");
      if (op_i == OP_MOV || op_i == OP_BIC || op_i == OP_BIS)
        assert_flags_kept_R8: assert (flag_upd_o == '0)
          else $error("flag update on flag-neutral code");
      if (op_i == OP_AND || op_i == OP_BIT || op_i == OP_XOR)
        assert_carry_not_zero_R6: assert (flags_o[FLG_C] == (result_o == '0 ? 1'b0 : 1'b1))
          else $error("logic carry does not mirror a non-zero result");
      if (flag_upd_o[FLG_Z])
        assert_zero_tracks_R10: assert (flags_o[FLG_Z] == (result_o == '0))
          else $error("Z flag disagrees with result");
    end
  end
endmodule

// File: tb/dual_op_alu_tb_top.sv
`timescale 1ns/1ps
module dual_op_alu_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  op;
  logic [15:0] src, dst;
  logic        byte_sel, cin;
  logic [15:0] res;
  logic        we;
  logic [3:0]  flg, upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dual_op_alu dut_i (
    .op_i(op), .src_i(src), .dst_i(dst), .byte_i(byte_sel), .carry_i(cin),
    .result_o(res), .wr_en_o(we), .flags_o(flg), .flag_upd_o(upd)
  );

  function automatic string tag_of(input logic [3:0] o, input logic b);
    string t;
    case (o)
      4'h4, 4'hC, 4'hD: t = "R8";
      4'h5, 4'h6:       t = "R2";
      4'h7, 4'h8:       t = "R3";
      4'h9:             t = "R4/R3";
      4'hA:             t = "R5";
      4'hB:             t = "R4/R6";
      4'hE:             t = "R7";
      4'hF:             t = "R6";
      default:          t = "R1";
    endcase
    if (b) t = {t, "/R9"};
    return t;
  endfunction

  task automatic model(input logic [3:0] o, input logic [15:0] s, input logic [15:0] d,
                       input logic b, input logic c,
                       output logic [15:0] r, output logic w,
                       output logic [3:0] f, output logic [3:0] u);
    int w_bits, msk, a, bb, sa, sd, tot, maxp, minn, cy;
    logic v, cf;
    w_bits = b ? 8 : 16;
    msk  = (1 << w_bits) - 1;
    maxp = (1 << (w_bits - 1)) - 1;
    minn = -(1 << (w_bits - 1));
    a  = int'(s) & msk;
    bb = int'(d) & msk;
    sa = (a  > maxp) ? a  - (1 << w_bits) : a;
    sd = (bb > maxp) ? bb - (1 << w_bits) : bb;
    r = '0; w = 1'b1; u = 4'b1111; v = 1'b0; cf = 1'b0;
    case (o)
      4'h4: begin r = 16'(a); u = 4'b0000; end
      4'hC: begin r = 16'((~a) & bb & msk); u = 4'b0000; end
      4'hD: begin r = 16'(a | bb); u = 4'b0000; end
      4'h5, 4'h6: begin
        cy  = (o == 4'h6) ? int'(c) : 0;
        tot = a + bb + cy;
        r = 16'(tot & msk); cf = tot > msk;
        v = (sa + sd + cy > maxp) || (sa + sd + cy < minn);
      end
      4'h7, 4'h8, 4'h9: begin
        cy  = (o == 4'h7) ? int'(c) : 1;
        tot = bb + (a ^ msk) + cy;
        r = 16'(tot & msk); cf = tot > msk;
        v = (sd - sa - 1 + cy > maxp) || (sd - sa - 1 + cy < minn);
        if (o == 4'h9) w = 1'b0;
      end
      4'hA: begin
        cy = int'(c);
        for (int k = 0; k < w_bits / 4; k++) begin
          int dg;
          dg = ((a >> (4*k)) & 15) + ((bb >> (4*k)) & 15) + cy;
          if (dg > 9) begin dg = (dg - 10) & 15; cy = 1; end
          else cy = 0;
          r = r | 16'(dg << (4*k));
        end
        cf = cy != 0;
      end
      4'hB, 4'hF: begin
        r = 16'(a & bb); cf = (a & bb) != 0;
        if (o == 4'hB) w = 1'b0;
      end
      4'hE: begin
        r = 16'(a ^ bb); cf = (a ^ bb) != 0;
        v = (sa < 0) && (sd < 0);
      end
      default: begin r = '0; w = 1'b0; u = 4'b0000; end
    endcase
    f = {v, r[w_bits-1], (r == 16'd0), cf};
  endtask

  task automatic expect_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [15:0] s, input logic [15:0] d,
                       input logic b, input logic c);
    logic [15:0] er; logic ew; logic [3:0] ef, eu;
    string t;
    @(posedge clk);
    op = o; src = s; dst = d; byte_sel = b; cin = c;
    @(negedge clk);
    model(o, s, d, b, c, er, ew, ef, eu);
    t = tag_of(o, b);
    expect_eq(t, "result", int'(res), int'(er));
    expect_eq(t, "wr_en", int'(we), int'(ew));
    expect_eq({t, "/R10"}, "flag_upd", int'(upd), int'(eu));
    expect_eq({t, "/R10"}, "flags", int'(flg & eu), int'(ef & eu));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    op = 4'h0; src = '0; dst = '0; byte_sel = 1'b0; cin = 1'b0;
    // Idle state (R1): code 0 drives nothing
    @(negedge clk);
    expect_eq("R1", "idle result", int'(res), 0);
    expect_eq("R1", "idle wr_en", int'(we), 0);
    expect_eq("R1", "idle upd", int'(upd), 0);
    // Directed corners
    apply(4'h3, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1);         // R1 unused code
    apply(4'h5, 16'h0001, 16'h7FFF, 1'b0, 1'b0);         // R2 signed overflow
    apply(4'h5, 16'h0001, 16'hFFFF, 1'b0, 1'b0);         // R2 carry, zero
    apply(4'h6, 16'h0000, 16'hFFFF, 1'b0, 1'b1);         // R2 carry-in
    apply(4'h8, 16'h0001, 16'h8000, 1'b0, 1'b0);         // R3 overflow
    apply(4'h8, 16'h0002, 16'h0001, 1'b0, 1'b0);         // R3 borrow, C=0
    apply(4'h7, 16'h0001, 16'h0001, 1'b0, 1'b0);         // R3 with carry 0
    apply(4'h9, 16'h1234, 16'h1234, 1'b0, 1'b0);         // R4 equal compare
    apply(4'hA, 16'h0001, 16'h9999, 1'b0, 1'b0);         // R5 full decimal carry
    apply(4'hA, 16'h0045, 16'h0055, 1'b0, 1'b1);         // R5 mid carry
    apply(4'hA, 16'h0001, 16'h1299, 1'b1, 1'b0);         // R5/R9 byte decimal
    apply(4'hF, 16'hF0F0, 16'h0F0F, 1'b0, 1'b0);         // R6 zero, C=0
    apply(4'hB, 16'h8001, 16'h8000, 1'b0, 1'b0);         // R4/R6 bit test
    apply(4'hE, 16'h8000, 16'hC000, 1'b0, 1'b0);         // R7 both negative
    apply(4'hE, 16'h0080, 16'h0080, 1'b1, 1'b0);         // R7/R9 byte
    apply(4'h4, 16'hABCD, 16'h0000, 1'b1, 1'b1);         // R8/R9 byte move
    apply(4'hC, 16'h00FF, 16'h1234, 1'b0, 1'b0);         // R8 bit clear
    apply(4'hD, 16'h0F00, 16'h00F0, 1'b0, 1'b0);         // R8 bit set
    apply(4'h5, 16'hFF7F, 16'hAA01, 1'b1, 1'b0);         // R9 byte overflow
    apply(4'h8, 16'h1201, 16'h3400, 1'b1, 1'b0);         // R9 byte borrow
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ro;
      ro = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(0, 3))
                                        : 4'($urandom_range(4, 15));
      apply(ro, 16'($urandom), 16'($urandom),
            ($urandom_range(0, 2) == 0), 1'($urandom));
    end
    finish_run();
  end
endmodule